// File: doc/BRIEF.md
# Field-Multiply Operand Sequencer

This block is the control unit between a small byte-wide host and a binary-field multiplier. The host writes three 16-bit addresses to it one byte at a time: the two operand addresses and the result address. Each byte is confirmed with a one-cycle acknowledge pulse. Once both operand addresses are known, the sequencer reads the two 21-byte field elements straight from a dual-ported SRAM. It hands them to the multiplier and starts it. When the multiplier reports completion, the sequencer writes the 163-bit product back to SRAM and raises a one-cycle completion pulse.

The host does not have to send the result address before the multiply. It may send it while the operands are loading or while the multiplier runs, which hides that transfer behind the arithmetic. If the product is ready before the result address is complete, the store waits for the address. The SRAM read port is synchronous: data for an address driven in one cycle appears in the next cycle.

Top module: `fos_sequencer`

## Requirements
- R1: While reset is held and in the first cycle after it, `host_ack`, `host_done`, `mem_we` and `mul_start` are low and `mem_addr` is zero.
- R2: A byte offered with `host_wr` and `host_start` both high while the sequencer is idle is accepted as the first address byte. `host_ack` is high for exactly the one cycle after each accepted byte.
- R3: The six address bytes arrive in this order: operand A low, A high, operand B low, B high, result C low, C high. Each address is 16 bits, low byte first. Only the first byte carries `host_start`.
- R4: Field elements are stored least significant byte first at increasing addresses. After the fourth address byte, `op_a` and `op_b` present the 163 bits read from the A and B regions, and the top 5 bits of byte 20 are dropped.
- R5: Reading takes 42 back-to-back cycles: A bytes 0..20, then B bytes 0..20. `mul_start` is a single-cycle pulse in the 43rd cycle after the cycle that follows the accepting edge of the fourth address byte.
- R6: The C address bytes may be sent during the load or the multiply. If the multiplier finishes before the C address is complete, no SRAM write occurs until it is.
- R7: The product is stored in 21 consecutive single-cycle writes to C+0..C+20, least significant byte first. The top 5 bits of the last byte are written as zero, and no other address is written.
- R8: `host_done` is high for exactly one cycle, in the cycle right after the last write.
- R9: A byte offered with `host_start` high while the sequencer is busy is ignored: it gets no acknowledge and changes no address. A byte without `host_start` while idle is also ignored.
- R10: `mul_done` has no effect unless the sequencer is waiting for the multiplier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host offers a byte this cycle |
| host_start | input | 1 | Marks the first byte of a new operation |
| host_data | input | 8 | Address byte from host |
| host_ack | output | 1 | One-cycle confirmation of an accepted byte |
| host_done | output | 1 | One-cycle completion interrupt |
| mem_addr | output | 16 | SRAM address for reads and writes |
| mem_rdata | input | 8 | SRAM read data, one cycle after address |
| mem_wdata | output | 8 | SRAM write data |
| mem_we | output | 1 | SRAM write enable |
| mul_start | output | 1 | One-cycle multiplier start |
| op_a | output | 163 | Operand A to multiplier |
| op_b | output | 163 | Operand B to multiplier |
| mul_done | input | 1 | Multiplier completion pulse |
| mul_result | input | 163 | Multiplier product, valid with `mul_done` |

## Verification
Three operation patterns are driven.

- **C address during the load:** with scattered, unrelated A, B and C regions, this separates correct byte ordering and address assembly from swapped or shifted forms.
- **C address after the product:** the A and B regions are adjacent, and the C address is sent only after the multiplier finishes. This shows whether the store waits for a complete address.
- **Interference during the load:** the result region overlaps operand A, and a stray start byte plus a stray `mul_done` arrive during the load. This shows whether busy-time inputs are truly ignored and whether the load completes before the region is overwritten.

Element contents are chosen so that the top byte often has its high bits set, which exposes a missing mask on both load and store.

// File: rtl/fos_pkg.sv
package fos_pkg;

  typedef enum logic [2:0] {
    FOS_IDLE,
    FOS_ADDR,
    FOS_LOAD,
    FOS_MUL,
    FOS_WAITC,
    FOS_STORE
  } fos_state_e;

  // Bytes needed to hold a field element of the given bit width.
  function automatic int elem_bytes(input int bits);
    return (bits + 7) / 8;
  endfunction

endpackage

// File: rtl/fos_elem_capture.sv
module fos_elem_capture #(
  parameter int FIELD_BITS = 163,
  parameter int IDX_W      = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [7:0]            wr_data,
  output logic [FIELD_BITS-1:0] elem
);

  // Only the bits that belong to the field are kept; the spare bits of the
  // top byte are never stored.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      elem <= '0;
    end else if (wr_en) begin
      for (int b = 0; b < FIELD_BITS; b++) begin
        if (IDX_W'(b / 8) == wr_idx) elem[b] <= wr_data[b % 8];
      end
    end
  end

endmodule

// File: rtl/fos_host_rx.sv
module fos_host_rx #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_idle,
  input  logic              host_wr,
  input  logic              host_start,
  input  logic [7:0]        host_data,
  output logic              byte_accept,
  output logic              host_ack,
  output logic              ops_ready,
  output logic              res_ready,
  output logic [ADDR_W-1:0] addr_a,
  output logic [ADDR_W-1:0] addr_b,
  output logic [ADDR_W-1:0] addr_c
);

  localparam int AB    = ADDR_W / 8;
  localparam int TOTAL = 3 * AB;
  localparam int IW    = $clog2(TOTAL + 1);
  localparam logic [IW-1:0] TOTAL_C  = IW'(TOTAL);
  localparam logic [IW-1:0] OPS_LAST = IW'(2 * AB - 1);

  logic [IW-1:0] idx;
  logic [IW-1:0] wr_slot;
  logic [7:0]    abytes [TOTAL];

  assign byte_accept = host_wr && (in_idle ? host_start
                                           : (!host_start && idx < TOTAL_C));
  assign wr_slot     = in_idle ? '0 : idx;
  assign ops_ready   = byte_accept && (wr_slot == OPS_LAST);
  assign res_ready   = (idx == TOTAL_C);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx      <= '0;
      host_ack <= 1'b0;
      for (int k = 0; k < TOTAL; k++) abytes[k] <= '0;
    end else begin
      host_ack <= byte_accept;
      if (byte_accept) begin
        abytes[wr_slot] <= host_data;
        idx             <= wr_slot + 1'b1;
      end
    end
  end

  always_comb begin
    for (int k = 0; k < AB; k++) begin
      addr_a[8*k +: 8] = abytes[k];
      addr_b[8*k +: 8] = abytes[AB + k];
      addr_c[8*k +: 8] = abytes[2*AB + k];
    end
  end

endmodule

// File: rtl/fos_sequencer.sv
module fos_sequencer
  import fos_pkg::*;
#(
  parameter int FIELD_BITS = 163,
  parameter int ADDR_W     = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  host_wr,
  input  logic                  host_start,
  input  logic [7:0]            host_data,
  output logic                  host_ack,
  output logic                  host_done,
  output logic [ADDR_W-1:0]     mem_addr,
  input  logic [7:0]            mem_rdata,
  output logic [7:0]            mem_wdata,
  output logic                  mem_we,
  output logic                  mul_start,
  output logic [FIELD_BITS-1:0] op_a,
  output logic [FIELD_BITS-1:0] op_b,
  input  logic                  mul_done,
  input  logic [FIELD_BITS-1:0] mul_result
);

  localparam int EB       = elem_bytes(FIELD_BITS);
  localparam int TOP_BITS = FIELD_BITS - 8 * (EB - 1);
  localparam int LOAD_CYC = 2 * EB + 1;
  localparam int CNT_W    = $clog2(LOAD_CYC + 1);
  localparam logic [CNT_W-1:0] EB_C       = CNT_W'(EB);
  localparam logic [CNT_W-1:0] TWO_EB     = CNT_W'(2 * EB);
  localparam logic [CNT_W-1:0] LOAD_LAST  = CNT_W'(LOAD_CYC - 1);
  localparam logic [CNT_W-1:0] STORE_LAST = CNT_W'(EB - 1);

  // Byte idx of the product, zero-extended so that spare top bits read as 0.
  function automatic logic [7:0] result_byte(input logic [FIELD_BITS-1:0] r,
                                             input logic [CNT_W-1:0] idx);
    logic [8*EB-1:0] wide;
    wide = (8*EB)'(r);
    return wide[8*idx +: 8];
  endfunction

  fos_state_e          state;
  logic [CNT_W-1:0]    cnt;
  logic [FIELD_BITS-1:0] result_q;
  logic                mul_start_q;
  logic                done_q;

  // Named internal events
  logic                in_idle;
  logic                byte_accept;
  logic                ops_ready;
  logic                res_ready;
  logic                load_issue;
  logic                store_issue;
  logic                cap_en;
  logic                cap_to_a;
  logic [CNT_W-1:0]    cap_idx;
  logic [ADDR_W-1:0]   addr_a;
  logic [ADDR_W-1:0]   addr_b;
  logic [ADDR_W-1:0]   addr_c;
  logic [FIELD_BITS-1:0] elem [2];

  assign in_idle     = (state == FOS_IDLE);
  assign load_issue  = (state == FOS_LOAD) && (cnt < TWO_EB);
  assign store_issue = (state == FOS_STORE);
  assign cap_en      = (state == FOS_LOAD) && (cnt != '0);
  assign cap_idx     = cnt - 1'b1;
  assign cap_to_a    = (cap_idx < EB_C);

  fos_host_rx #(.ADDR_W(ADDR_W)) u_host_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_idle     (in_idle),
    .host_wr     (host_wr),
    .host_start  (host_start),
    .host_data   (host_data),
    .byte_accept (byte_accept),
    .host_ack    (host_ack),
    .ops_ready   (ops_ready),
    .res_ready   (res_ready),
    .addr_a      (addr_a),
    .addr_b      (addr_b),
    .addr_c      (addr_c)
  );

  for (genvar g = 0; g < 2; g++) begin : g_elem
    logic             we;
    logic [CNT_W-1:0] slot;
    assign we   = cap_en && (cap_to_a == (g == 0));
    assign slot = (g == 0) ? cap_idx : cap_idx - EB_C;
    fos_elem_capture #(.FIELD_BITS(FIELD_BITS), .IDX_W(CNT_W)) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (we),
      .wr_idx  (slot),
      .wr_data (mem_rdata),
      .elem    (elem[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= FOS_IDLE;
      cnt         <= '0;
      result_q    <= '0;
      mul_start_q <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      mul_start_q <= 1'b0;
      done_q      <= 1'b0;
      case (state)
        FOS_IDLE:  if (byte_accept) state <= FOS_ADDR;
        FOS_ADDR:  if (ops_ready) begin
                     state <= FOS_LOAD;
                     cnt   <= '0;
                   end
        FOS_LOAD:  begin
                     cnt <= cnt + 1'b1;
                     if (cnt == LOAD_LAST) begin
                       state       <= FOS_MUL;
                       mul_start_q <= 1'b1;
                     end
                   end
        FOS_MUL:   if (mul_done) begin
                     result_q <= mul_result;
                     cnt      <= '0;
                     state    <= res_ready ? FOS_STORE : FOS_WAITC;
                   end
        FOS_WAITC: if (res_ready) state <= FOS_STORE;
        FOS_STORE: begin
                     cnt <= cnt + 1'b1;
                     if (cnt == STORE_LAST) begin
                       state  <= FOS_IDLE;
                       done_q <= 1'b1;
                     end
                   end
        default:   state <= FOS_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_addr = '0;
    if (load_issue) begin
      mem_addr = (cnt < EB_C) ? addr_a + ADDR_W'(cnt)
                              : addr_b + ADDR_W'(cnt - EB_C);
    end else if (store_issue) begin
      mem_addr = addr_c + ADDR_W'(cnt);
    end
  end

  assign mem_we    = store_issue;
  assign mem_wdata = store_issue ? result_byte(result_q, cnt) : 8'd0;
  assign mul_start = mul_start_q;
  assign host_done = done_q;
  assign op_a      = elem[0];
  assign op_b      = elem[1];

endmodule

// File: rtl/fos_sequencer_chk.sv
module fos_sequencer_chk #(
  parameter int ADDR_W   = 16,
  parameter int TOP_BITS = 3,
  parameter int EB       = 21
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr,
  input logic              host_start,
  input logic              host_ack,
  input logic              host_done,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_wdata,
  input logic              mul_start,
  input logic              byte_accept,
  input logic              in_idle,
  input logic [ADDR_W-1:0] addr_c
);

  assert_ack_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_accept |=> host_ack);

  assert_ack_needs_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_accept |=> !host_ack);

  assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_idle && host_wr && host_start) |-> !byte_accept);

  assert_mul_start_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mul_start |=> !mul_start);

  assert_top_byte_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_addr == addr_c + ADDR_W'(EB - 1)) |-> ((mem_wdata >> TOP_BITS) == 8'd0));

  assert_done_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |-> $past(mem_we));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |=> !host_done);

  assert_no_store_with_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mul_start));

endmodule

bind fos_sequencer fos_sequencer_chk #(
  .ADDR_W   (ADDR_W),
  .TOP_BITS (TOP_BITS),
  .EB       (EB)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .host_wr     (host_wr),
  .host_start  (host_start),
  .host_ack    (host_ack),
  .host_done   (host_done),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr),
  .mem_wdata   (mem_wdata),
  .mul_start   (mul_start),
  .byte_accept (byte_accept),
  .in_idle     (in_idle),
  .addr_c      (addr_c)
);

// File: tb/fos_sequencer_tb_top.sv
module fos_sequencer_tb_top;

  localparam int FB      = 163;
  localparam int AW      = 16;
  localparam int EB      = 21;
  localparam int MUL_LAT = 163;

  typedef struct packed {
    logic [15:0] a;
    logic [15:0] b;
    logic [15:0] c;
    logic [7:0]  seed;
    logic        late;
    logic        inject;
  } vec_t;

  localparam vec_t VECS [3] = '{
    '{16'h0A13, 16'h0257, 16'h0C80, 8'h11, 1'b0, 1'b0},
    '{16'h0300, 16'h0315, 16'h0700, 8'h6C, 1'b1, 1'b0},
    '{16'h0E00, 16'h0100, 16'h0E00, 8'hD3, 1'b0, 1'b1}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          host_wr, host_start;
  logic [7:0]    host_data;
  logic          host_ack, host_done;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_rdata, mem_wdata;
  logic          mem_we;
  logic          mul_start;
  logic [FB-1:0] op_a, op_b;
  logic          mul_done;
  logic [FB-1:0] mul_result;
  logic          mdl_done, force_done;
  logic [FB-1:0] mdl_res;

  logic [7:0] mem [0:4095];

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  int wr_cnt, done_cnt, last_we_cyc, done_cyc;

  always #5 clk = ~clk;

  assign mul_done   = mdl_done | force_done;
  assign mul_result = force_done ? {FB{1'b1}} : mdl_res;

  fos_sequencer dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_start (host_start),
    .host_data  (host_data),
    .host_ack   (host_ack),
    .host_done  (host_done),
    .mem_addr   (mem_addr),
    .mem_rdata  (mem_rdata),
    .mem_wdata  (mem_wdata),
    .mem_we     (mem_we),
    .mul_start  (mul_start),
    .op_a       (op_a),
    .op_b       (op_b),
    .mul_done   (mul_done),
    .mul_result (mul_result)
  );

  // Synchronous-read SRAM model
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[11:0]];
  end

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (mem_we) begin
      wr_cnt++;
      last_we_cyc = cyc;
    end
    if (host_done) begin
      done_cnt++;
      done_cyc = cyc;
    end
  end

  function automatic logic [7:0] fill(input logic [7:0] s, input int i);
    logic [7:0] v;
    v = 8'(s * 8'd29) ^ 8'(i * 53) ^ 8'(i << 5);
    return v + 8'h3B;
  endfunction

  function automatic logic [FB-1:0] elem_of(input logic [7:0] s);
    logic [8*EB-1:0] w;
    for (int i = 0; i < EB; i++) w[8*i +: 8] = fill(s, i);
    return w[FB-1:0];
  endfunction

  // Multiplier stand-in: any fixed mixing of the operands will do.
  function automatic logic [FB-1:0] mul_fn(input logic [FB-1:0] a, input logic [FB-1:0] b);
    return a ^ {b[0], b[FB-1:1]};
  endfunction

  initial begin
    logic [FB-1:0] cap_a, cap_b;
    mdl_done = 1'b0;
    mdl_res  = '0;
    forever begin
      @(negedge clk);
      mdl_done = 1'b0;
      if (mul_start) begin
        cap_a = op_a;
        cap_b = op_b;
        repeat (MUL_LAT - 1) @(negedge clk);
        mdl_res  = mul_fn(cap_a, cap_b);
        mdl_done = 1'b1;
      end
    end
  end

  task automatic check(input string req, input string what,
                       input logic [FB-1:0] act, input logic [FB-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Called at a negedge; returns at the next negedge.
  task automatic send_byte(input logic [7:0] d, input logic st,
                           input logic exp_ack, input string req);
    host_wr    = 1'b1;
    host_start = st;
    host_data  = d;
    @(negedge clk);
    host_wr    = 1'b0;
    host_start = 1'b0;
    check(req, "host_ack after offered byte", FB'(host_ack), FB'(exp_ack));
  endtask

  task automatic run_vec(input vec_t v);
    int t4, tms;
    logic [FB-1:0] exp_a, exp_b, exp_r;
    logic [8*EB-1:0] exp_w;
    for (int i = 0; i < EB; i++) begin
      mem[12'(v.a + 16'(i))] <= fill(v.seed, i);
      mem[12'(v.b + 16'(i))] <= fill(v.seed + 8'd1, i);
    end
    mem[12'(v.c - 16'd1)]  <= 8'h5A;
    mem[12'(v.c + 16'd21)] <= 8'hC3;
    exp_a = elem_of(v.seed);
    exp_b = elem_of(v.seed + 8'd1);
    exp_r = mul_fn(exp_a, exp_b);
    exp_w = (8*EB)'(exp_r);
    @(negedge clk);
    wr_cnt   = 0;
    done_cnt = 0;
    send_byte(v.a[7:0],  1'b1, 1'b1, "R2");
    send_byte(v.a[15:8], 1'b0, 1'b1, "R3");
    send_byte(v.b[7:0],  1'b0, 1'b1, "R3");
    send_byte(v.b[15:8], 1'b0, 1'b1, "R3");
    t4 = cyc;
    if (v.inject) begin
      send_byte(8'hEE, 1'b1, 1'b0, "R9");
      force_done = 1'b1;  // stray completion during load (R10)
      @(negedge clk);
      force_done = 1'b0;
    end
    if (!v.late) begin
      send_byte(v.c[7:0],  1'b0, 1'b1, "R3");
      send_byte(v.c[15:8], 1'b0, 1'b1, "R3");
    end
    while (!mul_start) @(negedge clk);
    tms = cyc;
    check("R5", "mul_start delay after fourth byte", FB'(tms - t4), FB'(43));
    check("R4", "op_a contents", op_a, exp_a);
    check("R4", "op_b contents", op_b, exp_b);
    if (v.late) begin
      while (!mdl_done) @(negedge clk);
      repeat (6) @(negedge clk);
      check("R6", "writes before result address", FB'(wr_cnt), FB'(0));
      send_byte(v.c[7:0],  1'b0, 1'b1, "R6");
      send_byte(v.c[15:8], 1'b0, 1'b1, "R6");
    end
    while (done_cnt == 0) @(negedge clk);
    check("R7", "number of writes", FB'(wr_cnt), FB'(EB));
    check("R8", "done delay after last write", FB'(done_cyc - last_we_cyc), FB'(1));
    @(negedge clk);
    check("R8", "host_done one cycle wide", FB'(host_done), FB'(0));
    for (int i = 0; i < EB; i++)
      check("R7", "stored result byte", FB'(mem[12'(v.c + 16'(i))]), FB'(exp_w[8*i +: 8]));
    check("R7", "byte below result untouched", FB'(mem[12'(v.c - 16'd1)]), FB'(8'h5A));
    check("R7", "byte above result untouched", FB'(mem[12'(v.c + 16'd21)]), FB'(8'hC3));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n      = 1'b0;
    host_wr    = 1'b0;
    host_start = 1'b0;
    host_data  = 8'd0;
    force_done = 1'b0;
    wr_cnt     = 0;
    done_cnt   = 0;
    repeat (3) @(negedge clk);
    check("R1", "outputs in reset",
          FB'({host_ack, host_done, mem_we, mul_start}), FB'(0));
    check("R1", "mem_addr in reset", FB'(mem_addr), FB'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "outputs after reset",
          FB'({host_ack, host_done, mem_we, mul_start}), FB'(0));

    // Idle byte without start is ignored (R9)
    send_byte(8'h42, 1'b0, 1'b0, "R9");
    // Stray completion while idle is ignored (R10)
    force_done = 1'b1;
    @(negedge clk);
    force_done = 1'b0;
    repeat (3) @(negedge clk);
    check("R10", "writes after idle mul_done", FB'(wr_cnt), FB'(0));
    check("R10", "done after idle mul_done", FB'(done_cnt), FB'(0));

    foreach (VECS[k]) run_vec(VECS[k]);

    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule